// File: doc/BRIEF.md
# Iterative Bitsliced Block Encryptor

This core encrypts one 128-bit block with a 32-round substitution-permutation cipher and completes one round per clock. The block is kept as four 32-bit words. Each round XORs in a 128-bit round key and passes every bit column of the four words through a 4-bit substitution box. The box changes with the round number and cycles through eight boxes. A fixed mixing step built from rotates, zero-fill shifts and XORs then combines the words. The last round has no mixing step. A second key XOR with an extra subkey takes its place.

Key expansion is done outside the core. While busy, the core asks for one subkey per cycle: it raises a request flag and drives a round index. The subkey for that index must arrive on the key input in the same cycle, from a combinational lookup or from a register that the surrounding logic steps in lockstep. One encryption takes 33 key cycles, indices 0 to 32. A one-cycle done pulse follows, and the ciphertext stays valid until the next accepted start.

Top module: `bsl_enc_core`

## Requirements
- R1: While reset is held, and in the first cycle after it, done_o and rk_req_o are 0 and ctext_o is all zeros.
- R2: A start_i pulse sampled while idle loads ptext_i as the state. Word j is bits [32j+31:32j]. The first request cycle follows in the next cycle. A start sampled in the same cycle that done_o is high is accepted.
- R3: After an accepted start, rk_req_o stays high for exactly 33 consecutive cycles, and rk_idx_o counts 0, 1, ..., 32 in those cycles.
- R4: Each key cycle XORs state word j with bits [32j+31:32j] of rk_i as presented in that cycle.
- R5: Round r (0..31) applies box number r mod 8 to every bit column i. The nibble is {word3[i], word2[i], word1[i], word0[i]} with word 0 as the LSB, and the result goes back to the same column. Boxes 0..7 map 0..15 to the sequences listed in the package.
- R6: Rounds 0 to 30 follow the box with the word mixing: rol w0 by 13 and w2 by 3; w1 ^= w0^w2 and w3 ^= w2^(w0<<3); rol w1 by 1 and w3 by 7; w0 ^= w1^w3 and w2 ^= w3^(w1<<7); rol w0 by 5 and w2 by 22. Both shifts fill with zeros.
- R7: Round 31 skips the mixing. Key cycle 32 only XORs subkey 32 into the state, so a change of subkey 32 by a value D changes the ciphertext by exactly D.
- R8: done_o is high for exactly one cycle, the cycle after the index-32 request. ctext_o then holds the ciphertext unchanged until the next accepted start.
- R9: A start_i pulse while rk_req_o is high is ignored. Indexing continues without a break, and the result is that of the first plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an encryption (used only when idle) |
| ptext_i | input | 128 | Plaintext block, sampled with an accepted start |
| rk_req_o | output | 1 | Subkey requested this cycle |
| rk_idx_o | output | 6 | Index of the requested subkey (0..32) |
| rk_i | input | 128 | Subkey for rk_idx_o, same cycle |
| done_o | output | 1 | One-cycle pulse: ctext_o is valid |
| ctext_o | output | 128 | Ciphertext block |

## Verification
The hardest situations to reach are a start that arrives mid-run and a start placed exactly on the done cycle. Both depend on where the stimulus sits relative to the 33-cycle key window. The bench counts clock edges from each accepted start, pulses start ten cycles into a run with a different plaintext, and issues the next start in the very cycle done is seen. Subkey 32 is isolated by running the same plaintext twice with only that subkey perturbed and comparing the XOR of the two results. An all-zero key and plaintext vector drives uniform columns through every box.

// File: rtl/bsl_enc_pkg.sv
package bsl_enc_pkg;
   localparam int WORD_W  = 32;
   localparam int NWORDS  = 4;
   localparam int BLK_W   = WORD_W * NWORDS;
   localparam int NUM_BOX = 8;
   localparam int SEL_W   = $clog2(NUM_BOX);

   typedef logic [NWORDS-1:0][WORD_W-1:0] blk_t;

   // Box b output for input x sits at bits [4x+3:4x] of entry b.
   localparam logic [63:0] BOX_LUT [NUM_BOX] = '{
      64'hC90724DEB56A1F83,
      64'h43D68EB1A50972CF,
      64'h25B04E1DFAC39768,
      64'hE57A421D369C8BF0,
      64'hD7E9A4526B0C38F1,
      64'h176D8E30C9A4B25F,
      64'h0A3DF19EB6485C27,
      64'h6539AC47B28E0FD1
   };

   function automatic logic [3:0] box_apply(input logic [SEL_W-1:0] sel,
                                            input logic [3:0] x);
      logic [63:0] row;
      row = BOX_LUT[sel];
      return row[{x, 2'b00} +: 4];
   endfunction
endpackage

// File: rtl/bsl_round_ctrl.sv
module bsl_round_ctrl #(
   parameter int ROUNDS = 32,
   localparam int IDX_W = $clog2(ROUNDS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             load_o,
   output logic             busy_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             done_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROUNDS);

   logic             busy_q;
   logic [IDX_W-1:0] idx_q;
   logic             done_q;
   logic             at_last;

   assign load_o  = start_i && !busy_q;
   assign at_last = busy_q && (idx_q == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= at_last;
         if (load_o) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
         end else if (at_last) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else if (busy_q) begin
            idx_q  <= idx_q + 1'b1;
         end
      end
   end

   assign busy_o = busy_q;
   assign idx_o  = idx_q;
   assign done_o = done_q;
endmodule

// File: rtl/bsl_sbox_layer.sv
module bsl_sbox_layer
   import bsl_enc_pkg::*;
(
   input  logic [SEL_W-1:0] sel_i,
   input  blk_t             din_i,
   output blk_t             dout_o
);
   for (genvar i = 0; i < WORD_W; i++) begin : g_col
      logic [3:0] nib_in;
      logic [3:0] nib_out;
      assign nib_in  = {din_i[3][i], din_i[2][i], din_i[1][i], din_i[0][i]};
      assign nib_out = box_apply(sel_i, nib_in);
      for (genvar w = 0; w < NWORDS; w++) begin : g_wr
         assign dout_o[w][i] = nib_out[w];
      end
   end
endmodule

// File: rtl/bsl_lin_mix.sv
module bsl_lin_mix
   import bsl_enc_pkg::*;
#(
   parameter int ROT_A0 = 13,
   parameter int ROT_A2 = 3,
   parameter int SHL_A  = 3,
   parameter int ROT_B1 = 1,
   parameter int ROT_B3 = 7,
   parameter int SHL_B  = 7,
   parameter int ROT_C0 = 5,
   parameter int ROT_C2 = 22
) (
   input  blk_t din_i,
   output blk_t dout_o
);
   function automatic logic [WORD_W-1:0] rol(input logic [WORD_W-1:0] v, input int n);
      return (v << n) | (v >> (WORD_W - n));
   endfunction

   logic [WORD_W-1:0] a0, a1, a2, a3;
   logic [WORD_W-1:0] b0, b1, b2, b3;

   always_comb begin
      a0 = rol(din_i[0], ROT_A0);
      a2 = rol(din_i[2], ROT_A2);
      a1 = din_i[1] ^ a0 ^ a2;
      a3 = din_i[3] ^ a2 ^ (a0 << SHL_A);
      b1 = rol(a1, ROT_B1);
      b3 = rol(a3, ROT_B3);
      b0 = a0 ^ b1 ^ b3;
      b2 = a2 ^ b3 ^ (b1 << SHL_B);
      dout_o[0] = rol(b0, ROT_C0);
      dout_o[1] = b1;
      dout_o[2] = rol(b2, ROT_C2);
      dout_o[3] = b3;
   end
endmodule

// File: rtl/bsl_enc_core.sv
module bsl_enc_core
   import bsl_enc_pkg::*;
#(
   parameter int ROUNDS = 32,
   localparam int IDX_W = $clog2(ROUNDS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [BLK_W-1:0] ptext_i,
   output logic             rk_req_o,
   output logic [IDX_W-1:0] rk_idx_o,
   input  logic [BLK_W-1:0] rk_i,
   output logic             done_o,
   output logic [BLK_W-1:0] ctext_o
);
   if (ROUNDS < 2) begin : g_bad_rounds
      $error("bsl_enc_core: ROUNDS must be at least 2");
   end
   if (NWORDS != 4) begin : g_bad_words
      $error("bsl_enc_core: the box layer needs exactly four words");
   end

   localparam logic [IDX_W-1:0] FINAL_BOX_IDX = IDX_W'(ROUNDS - 1);
   localparam logic [IDX_W-1:0] POST_KEY_IDX  = IDX_W'(ROUNDS);

   logic             load;
   logic             busy;
   logic [IDX_W-1:0] idx;
   blk_t             state_q;
   blk_t             keyed;
   blk_t             boxed;
   blk_t             mixed;
   blk_t             next_state;
   logic [SEL_W-1:0] box_sel;

   bsl_round_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_o  (load),
      .busy_o  (busy),
      .idx_o   (idx),
      .done_o  (done_o)
   );

   assign keyed   = state_q ^ blk_t'(rk_i);
   assign box_sel = idx[SEL_W-1:0];

   bsl_sbox_layer u_box (
      .sel_i  (box_sel),
      .din_i  (keyed),
      .dout_o (boxed)
   );

   bsl_lin_mix u_mix (
      .din_i  (boxed),
      .dout_o (mixed)
   );

   always_comb begin
      if (idx == POST_KEY_IDX)       next_state = keyed;
      else if (idx == FINAL_BOX_IDX) next_state = boxed;
      else                           next_state = mixed;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     state_q <= '0;
      else if (load)  state_q <= blk_t'(ptext_i);
      else if (busy)  state_q <= next_state;
   end

   assign rk_req_o = busy;
   assign rk_idx_o = idx;
   assign ctext_o  = state_q;
endmodule

// File: rtl/bsl_enc_core_chk.sv
module bsl_enc_core_chk #(
   parameter int ROUNDS = 32,
   parameter int IDX_W  = 6,
   parameter int BLK_W  = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             rk_req_o,
   input logic [IDX_W-1:0] rk_idx_o,
   input logic             done_o,
   input logic [BLK_W-1:0] ctext_o
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS);

   // R3: the index advances by one on every request cycle before the last
   a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rk_req_o && rk_idx_o != LAST) |=> (rk_req_o && rk_idx_o == $past(rk_idx_o) + 1'b1));

   // R3: the first request after idle carries index 0
   a_r3_first_idx: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rk_req_o) |-> (rk_idx_o == '0));

   // R8: done follows the last request and lasts one cycle
   a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (rk_req_o && rk_idx_o == LAST) |=> (done_o && !rk_req_o));
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: ciphertext holds while idle and no start arrives
   a_r8_ctext_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rk_req_o && !start_i) |=> $stable(ctext_o));

   // R9: a start during a run does not restart the index
   a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (rk_req_o && start_i && rk_idx_o != LAST) |=> (rk_idx_o != '0));

   // R1: nothing is requested or reported while reset is held
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!rk_req_o && !done_o));
endmodule

bind bsl_enc_core bsl_enc_core_chk #(
   .ROUNDS (ROUNDS),
   .IDX_W  (IDX_W),
   .BLK_W  (bsl_enc_pkg::BLK_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .rk_req_o (rk_req_o),
   .rk_idx_o (rk_idx_o),
   .done_o   (done_o),
   .ctext_o  (ctext_o)
);

// File: tb/bsl_enc_core_tb_top.sv
module bsl_enc_core_tb_top;
   localparam int NVEC = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [127:0] ptext = '0;
   logic         rk_req;
   logic [5:0]   rk_idx;
   logic [127:0] rk;
   logic         done;
   logic [127:0] ctext;
   logic [31:0]  seed = 32'h1;
   logic [127:0] k32_delta = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   localparam int B0 [16] = '{3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12};
   localparam int B1 [16] = '{15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4};
   localparam int B2 [16] = '{8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2};
   localparam int B3 [16] = '{0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14};
   localparam int B4 [16] = '{1,15,8,3,12,0,11,6,2,5,4,10,9,14,7,13};
   localparam int B5 [16] = '{15,5,2,11,4,10,9,12,0,3,14,8,13,6,7,1};
   localparam int B6 [16] = '{7,2,12,5,8,4,6,11,14,9,1,15,13,3,10,0};
   localparam int B7 [16] = '{1,13,15,0,14,8,2,11,7,4,12,10,9,3,5,6};

   localparam logic [127:0] VEC_PT [NVEC] = '{
      128'h0,
      128'h00112233_44556677_8899AABB_CCDDEEFF,
      128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
      128'h80000000_00000000_00000000_00000001,
      128'hDEADBEEF_01234567_89ABCDEF_FEDCBA98,
      128'h0F0F0F0F_F0F0F0F0_33333333_CCCCCCCC
   };
   localparam logic [31:0] VEC_SEED [NVEC] = '{
      32'h0, 32'h1, 32'h5A5A1234, 32'h0, 32'hCAFEF00D, 32'h13579BDF
   };

   function automatic int box_of(int b, int x);
      case (b)
         0: return B0[x]; 1: return B1[x]; 2: return B2[x]; 3: return B3[x];
         4: return B4[x]; 5: return B5[x]; 6: return B6[x]; default: return B7[x];
      endcase
   endfunction

   function automatic logic [31:0] rl(logic [31:0] v, int n);
      return (v << n) | (v >> (32 - n));
   endfunction

   // Seed 0 gives an all-zero key schedule.
   function automatic logic [127:0] key_of(logic [31:0] s, int idx, logic [127:0] d32);
      logic [127:0] k;
      for (int w = 0; w < 4; w++) begin
         logic [31:0] kw;
         kw = s ^ (32'(idx + 1) * 32'h9E3779B9) ^ (32'(w) * 32'h7F4A7C15);
         kw = rl(kw, 13) + 32'(idx);
         k[32*w +: 32] = (s == 0) ? 32'h0 : kw;
      end
      if (idx == 32) k = k ^ d32;
      return k;
   endfunction

   function automatic logic [127:0] model(logic [127:0] pt, logic [31:0] s, logic [127:0] d32);
      logic [31:0] x [4];
      logic [31:0] y [4];
      logic [127:0] k;
      for (int w = 0; w < 4; w++) x[w] = pt[32*w +: 32];
      for (int r = 0; r < 32; r++) begin
         k = key_of(s, r, d32);
         for (int w = 0; w < 4; w++) x[w] = x[w] ^ k[32*w +: 32];
         for (int w = 0; w < 4; w++) y[w] = '0;
         for (int i = 0; i < 32; i++) begin
            int nib;
            int o;
            nib = {28'd0, x[3][i], x[2][i], x[1][i], x[0][i]};
            o = box_of(r % 8, nib);
            for (int w = 0; w < 4; w++) y[w][i] = o[w];
         end
         if (r < 31) begin
            y[0] = rl(y[0], 13);
            y[2] = rl(y[2], 3);
            y[1] = y[1] ^ y[0] ^ y[2];
            y[3] = y[3] ^ y[2] ^ (y[0] << 3);
            y[1] = rl(y[1], 1);
            y[3] = rl(y[3], 7);
            y[0] = y[0] ^ y[1] ^ y[3];
            y[2] = y[2] ^ y[3] ^ (y[1] << 7);
            y[0] = rl(y[0], 5);
            y[2] = rl(y[2], 22);
         end
         for (int w = 0; w < 4; w++) x[w] = y[w];
      end
      k = key_of(s, 32, d32);
      for (int w = 0; w < 4; w++) x[w] = x[w] ^ k[32*w +: 32];
      return {x[3], x[2], x[1], x[0]};
   endfunction

   assign rk = key_of(seed, int'(rk_idx), k32_delta);

   bsl_enc_core dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .ptext_i  (ptext),
      .rk_req_o (rk_req),
      .rk_idx_o (rk_idx),
      .rk_i     (rk),
      .done_o   (done),
      .ctext_o  (ctext)
   );

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // Pulse start at a negedge, then follow the run; returns the ciphertext
   // seen in the done cycle (34 negedges after the start negedge).
   task automatic run_one(logic [127:0] pt, string tag, output logic [127:0] res,
                          input int stray_at, input logic [127:0] stray_pt);
      bit idx_ok;
      bit req_ok;
      idx_ok = 1;
      req_ok = 1;
      start = 1'b1;
      ptext = pt;
      for (int j = 0; j < 33; j++) begin
         @(negedge clk);
         start = (j == stray_at) ? 1'b1 : 1'b0;
         if (j == stray_at) ptext = stray_pt;
         if (!rk_req || rk_idx != 6'(j)) begin
            idx_ok = 0;
            if (req_ok) $display("  index mismatch at step %0d: req=%0b idx=%0d", j, rk_req, rk_idx);
            req_ok = 0;
         end
      end
      start = 1'b0;
      @(negedge clk);
      chk({"R3 index walk ", tag}, {127'd0, idx_ok}, 128'd1);
      chk({"R8 done in cycle 34 ", tag}, {127'd0, done}, 128'd1);
      chk({"R3 request dropped ", tag}, {127'd0, rk_req}, 128'd0);
      res = ctext;
   endtask

   initial begin
      #(4 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [127:0] res;
      logic [127:0] res2;
      logic [127:0] exp_a;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 done in reset", {127'd0, done}, 128'd0);
      chk("R1 request in reset", {127'd0, rk_req}, 128'd0);
      chk("R1 ciphertext in reset", ctext, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 quiet after reset", {126'd0, done, rk_req}, 128'd0);

      // R2 R4 R5 R6 R7: vector table
      for (int v = 0; v < NVEC; v++) begin
         seed = VEC_SEED[v];
         k32_delta = '0;
         run_one(VEC_PT[v], $sformatf("vec%0d", v), res, -1, '0);
         chk($sformatf("R4 R5 R6 R7 ciphertext vec%0d", v), res, model(VEC_PT[v], VEC_SEED[v], '0));
         @(negedge clk);
         chk("R8 done single cycle", {127'd0, done}, 128'd0);
         chk("R8 ciphertext holds", ctext, res);
         repeat (3) @(negedge clk);
         chk("R8 ciphertext holds idle", ctext, res);
      end

      // R7: perturb subkey 32 only
      seed = 32'h2468ACE0;
      k32_delta = '0;
      run_one(VEC_PT[1], "k32 base", res, -1, '0);
      @(negedge clk);
      k32_delta = 128'hA5A5A5A5_00000001_80000000_0F0F0F0F;
      run_one(VEC_PT[1], "k32 alt", res2, -1, '0);
      chk("R7 subkey 32 plain XOR", res ^ res2, 128'hA5A5A5A5_00000001_80000000_0F0F0F0F);
      k32_delta = '0;
      @(negedge clk);

      // R9: stray start ten cycles into a run
      seed = VEC_SEED[4];
      run_one(VEC_PT[4], "stray start", res, 10, VEC_PT[5]);
      chk("R9 stray start ignored", res, model(VEC_PT[4], VEC_SEED[4], '0));

      // R2: start issued in the done cycle is accepted
      seed = VEC_SEED[2];
      start = 1'b1;
      ptext = VEC_PT[3];
      for (int j = 0; j < 33; j++) begin
         @(negedge clk);
         start = 1'b0;
      end
      @(negedge clk);
      chk("R8 done before back-to-back", {127'd0, done}, 128'd1);
      exp_a = model(VEC_PT[3], VEC_SEED[2], '0);
      chk("R2 first of back-to-back", ctext, exp_a);
      run_one(VEC_PT[2], "back-to-back", res, -1, '0);
      chk("R2 start on done cycle", res, model(VEC_PT[2], VEC_SEED[2], '0));

      // R1: reset in the middle of a run
      @(negedge clk);
      start = 1'b1;
      ptext = VEC_PT[4];
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid-run reset request", {127'd0, rk_req}, 128'd0);
      chk("R1 mid-run reset ciphertext", ctext, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {126'd0, done, rk_req}, 128'd0);

      finish_run();
   end
endmodule